// File: doc/BRIEF.md
# Sprite Table DMA Engine

This engine fills the 160-byte sprite attribute table from system memory. A CPU write delivers a 16-bit base address on a one-cycle trigger. The engine then reads consecutive bytes over a master read port and writes each one into the table at a rising index. All timing is counted on a machine-cycle enable (`tick`). The start is delayed. After the start, bytes move at a fixed spacing. A new trigger during a transfer abandons the old one and begins again from the new base.

While the engine runs, the CPU must not touch memory that the engine's reads could collide with. The engine therefore publishes a lockout window `[lock_lo, lock_hi)`. The window is chosen from bits [15:13] of the current source pointer, using one of two tables picked by `model_sel`. The address decoder gates this window with `busy`. The engine's own reads do not pass through that check.

Top module: `sprite_dma`

## Requirements
- R1: After reset, `busy` is 0, `wr_en` and `rd_en` are 0, and the source pointer is 0x0000.
- R2: A trigger whose base is above 0xF100 has no effect. This holds when the engine is idle and when a transfer is running, and the running transfer continues unchanged. A base of exactly 0xF100 is accepted.
- R3: An accepted trigger loads the source pointer with the base and the destination index with 0, and schedules 160 byte moves. `busy` is 1 from the next cycle.
- R4: Ticks are counted from the cycle after the accepting cycle. The first move happens on the 8th tick. Each later move happens on the 4th tick after the previous move. Cycles with `tick` low do not count.
- R5: In a move cycle, `rd_en` and `wr_en` are 1, `rd_addr` is the source pointer, `wr_idx` is the destination index, and `wr_data` equals `rd_data` in the same cycle. After the move, the source pointer and the destination index each increase by 1.
- R6: An accepted trigger during a transfer drops the pending schedule and restarts from the new base, with index 0 and the full 8-tick delay. No move happens in the cycle of that trigger.
- R7: `busy` stays 1 until the 160th move and is 0 from the cycle after it. No write happens while `busy` is 0.
- R8: With `model_sel` = 0, source bits [15:13] = 4 give the window 0x8000 to 0xA000. Every other value gives 0xA000 to 0xFE00. `lock_hi` is exclusive.
- R9: With `model_sel` = 1, source bits [15:13] = 4 give 0x8000 to 0xA000, a value of 6 gives 0xC000 to 0xFE00, and every other value gives 0xA000 to 0xC000.
- R10: The window follows the current source pointer, including when the pointer crosses an 8 KiB boundary in the middle of a transfer. It always reflects the pointer, whether or not the engine is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle enable |
| model_sel | input | 1 | Lockout table select |
| trig | input | 1 | Start strobe from the CPU register write |
| trig_base | input | 16 | Source base address carried with the strobe |
| rd_en | output | 1 | Master read strobe |
| rd_addr | output | 16 | Master read address (current source pointer) |
| rd_data | input | 8 | Read data, valid in the same cycle |
| wr_en | output | 1 | Table write strobe |
| wr_idx | output | 8 | Table write index |
| wr_data | output | 8 | Table write data |
| busy | output | 1 | Transfer in progress |
| lock_lo | output | 16 | Lockout window start |
| lock_hi | output | 16 | Lockout window end (exclusive) |

## Verification
The bench walks every value of source bits [15:13] under both lockout tables, using sparse tick patterns. A decoder with a swapped table entry, or a spacing counter that counted idle cycles, would write at the wrong tick or publish the wrong window. It probes the 0xF100/0xF101 acceptance edge, both idle and mid-transfer. A wrong comparison would start a stray copy or disturb the running one. It restarts a transfer partway through, which exposes an engine that kept its old index or skipped the long start delay. It also runs sources that cross an 8 KiB boundary, where a window latched at start would stay stale.

// File: rtl/sprite_dma.sv
module sprite_dma #(
  parameter int          LEN        = 160,
  parameter int          START_WAIT = 8,
  parameter int          STEP_WAIT  = 4,
  parameter logic [15:0] MAX_BASE   = 16'hF100,
  localparam int IW = $clog2(LEN),
  localparam int CW = $clog2(LEN + 1),
  localparam int WM = (START_WAIT > STEP_WAIT) ? START_WAIT : STEP_WAIT,
  localparam int WW = $clog2(WM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          model_sel,
  input  logic          trig,
  input  logic [15:0]   trig_base,
  output logic          rd_en,
  output logic [15:0]   rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          busy,
  output logic [15:0]   lock_lo,
  output logic [15:0]   lock_hi
);
  logic [15:0]   src;
  logic [IW-1:0] dst;
  logic [CW-1:0] left;
  logic [WW-1:0] wcnt;
  logic          accept, move;

  assign accept  = trig && (trig_base <= MAX_BASE);
  assign busy    = (left != '0);
  assign move    = busy && tick && !accept && (wcnt == WW'(1));

  assign rd_en   = move;
  assign rd_addr = src;
  assign wr_en   = move;
  assign wr_idx  = dst;
  assign wr_data = rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= '0;
      dst  <= '0;
      left <= '0;
      wcnt <= '0;
    end else if (accept) begin
      src  <= trig_base;
      dst  <= '0;
      left <= CW'(LEN);
      wcnt <= WW'(START_WAIT);
    end else if (busy && tick) begin
      if (wcnt == WW'(1)) begin
        src  <= src + 16'd1;
        dst  <= dst + IW'(1);
        left <= left - CW'(1);
        wcnt <= WW'(STEP_WAIT);
      end else begin
        wcnt <= wcnt - WW'(1);
      end
    end
  end

  always_comb begin
    lock_lo = 16'hA000;
    lock_hi = model_sel ? 16'hC000 : 16'hFE00;
    if (src[15:13] == 3'd4) begin
      lock_lo = 16'h8000;
      lock_hi = 16'hA000;
    end else if (model_sel && src[15:13] == 3'd6) begin
      lock_lo = 16'hC000;
      lock_hi = 16'hFE00;
    end
  end
endmodule

// File: rtl/sprite_dma_chk.sv
module sprite_dma_chk #(
  parameter int          LEN        = 160,
  parameter int          START_WAIT = 8,
  parameter int          STEP_WAIT  = 4,
  parameter logic [15:0] MAX_BASE   = 16'hF100,
  localparam int IW = $clog2(LEN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          model_sel,
  input logic          trig,
  input logic [15:0]   trig_base,
  input logic          rd_en,
  input logic [15:0]   rd_addr,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic          busy,
  input logic [15:0]   lock_lo,
  input logic [15:0]   lock_hi
);
  p_reject_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && trig_base > MAX_BASE) |=> !busy);

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && trig_base <= MAX_BASE) |=> (busy && rd_addr == $past(trig_base)));

  p_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (START_WAIT > 1 && trig && trig_base <= MAX_BASE) |=> !wr_en);

  p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (STEP_WAIT > 1 && wr_en) |=> !wr_en);

  p_read_with_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> rd_en);

  p_src_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_addr == $past(rd_addr) + 16'd1));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);

  p_last_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IW'(LEN - 1)) |=> !busy);

  p_lock_m0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!model_sel && rd_addr[15:13] != 3'd4) |-> (lock_lo == 16'hA000 && lock_hi == 16'hFE00));

  p_lock_m1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (model_sel && rd_addr[15:13] == 3'd6) |-> (lock_lo == 16'hC000 && lock_hi == 16'hFE00));
endmodule

bind sprite_dma sprite_dma_chk #(
  .LEN(LEN), .START_WAIT(START_WAIT), .STEP_WAIT(STEP_WAIT), .MAX_BASE(MAX_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .model_sel(model_sel), .trig(trig), .trig_base(trig_base),
  .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_idx(wr_idx), .busy(busy),
  .lock_lo(lock_lo), .lock_hi(lock_hi)
);

// File: tb/sim_sprite_dma.sv
module sim_sprite_dma;
  logic        clk = 0, rst_n = 0, tick = 0, model_sel = 0, trig = 0;
  logic [15:0] trig_base = 0;
  logic        rd_en, wr_en, busy;
  logic [15:0] rd_addr, lock_lo, lock_hi;
  logic [7:0]  rd_data, wr_data, wr_idx;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign rd_data = mem(rd_addr);

  sprite_dma u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .model_sel(model_sel), .trig(trig),
    .trig_base(trig_base), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .busy(busy),
    .lock_lo(lock_lo), .lock_hi(lock_hi)
  );

  int     nchk = 0, nbad = 0, cyc = 0;
  string  ctx = "R1";
  logic   mbusy = 0;
  logic [15:0] msrc = 0;
  int     mk = 0, mticks = 0;
  bit     done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s (%s) cycle %0d: actual %0h expected %0h", req, ctx, cyc, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic tr, input logic [15:0] b);
    logic acc, ew;
    logic [15:0] elo, ehi;
    @(negedge clk);
    tick = t; trig = tr; trig_base = b;
    cyc++;
    #5;
    acc = tr && (b <= 16'hF100);
    ew  = 0;
    if (!acc && mbusy && t) begin
      mticks++;
      ew = (mticks == 8 + 4 * mk);
    end
    chk(busy == mbusy, "R7", busy, mbusy);
    chk(wr_en == ew, "R4", wr_en, ew);
    chk(rd_en == ew, "R5", rd_en, ew);
    if (ew) begin
      chk(wr_idx == mk[7:0], "R5", wr_idx, mk);
      chk(rd_addr == msrc, "R5", rd_addr, msrc);
      chk(wr_data == mem(msrc), "R5", wr_data, mem(msrc));
    end
    elo = 16'hA000;
    ehi = model_sel ? 16'hC000 : 16'hFE00;
    if (msrc[15:13] == 3'd4) begin elo = 16'h8000; ehi = 16'hA000; end
    else if (model_sel && msrc[15:13] == 3'd6) begin elo = 16'hC000; ehi = 16'hFE00; end
    chk(lock_lo == elo, model_sel ? "R9" : "R8", lock_lo, elo);
    chk(lock_hi == ehi, "R10", lock_hi, ehi);
    if (ew) begin
      mk++; msrc++;
      if (mk == 160) mbusy = 0;
    end
    if (acc) begin
      mbusy = 1; msrc = b; mk = 0; mticks = 0;
    end
  endtask

  task automatic run(input int n, input int tmod);
    for (int i = 0; i < n && mbusy; i++) step((cyc % tmod) == 0, 1'b0, 16'h0);
  endtask

  task automatic finish_run(input int tmod);
    run(20000, tmod);
    step(1'b1, 1'b0, 16'h0);
    chk(!busy, "R7", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    ctx = "R1";
    step(1'b1, 1'b0, 16'h0);
    chk(!busy && !wr_en && rd_addr == 16'h0, "R1", rd_addr, 0);

    ctx = "R3";
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 8; r++) begin
        model_sel = m[0];
        step(1'b1, 1'b1, (r == 7) ? 16'hE000 : ((16'(r) << 13) + 16'(r) * 16'h0011));
        finish_run(1 + (r % 3));
      end

    ctx = "R4";
    model_sel = 0;
    step(1'b1, 1'b1, 16'h0100);
    finish_run(5);

    ctx = "R2";
    step(1'b1, 1'b1, 16'hF101);
    repeat (12) step(1'b1, 1'b0, 16'h0);
    chk(!busy, "R2", busy, 0);
    step(1'b1, 1'b1, 16'hF100);
    finish_run(1);
    step(1'b1, 1'b1, 16'h1200);
    run(100, 2);
    step(1'b1, 1'b1, 16'hFFFF);
    finish_run(2);

    ctx = "R6";
    model_sel = 1;
    step(1'b1, 1'b1, 16'h3000);
    run(200, 1);
    step(1'b1, 1'b1, 16'h5500);
    chk(!wr_en, "R6", wr_en, 0);
    while (mbusy && !(mk == 1)) step(1'b1, 1'b0, 16'h0);
    chk(msrc == 16'h5501, "R6", msrc, 16'h5501);
    finish_run(1);

    ctx = "R10";
    step(1'b1, 1'b1, 16'h9FC0);
    finish_run(1);
    model_sel = 0;
    step(1'b1, 1'b1, 16'h7F80);
    finish_run(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog (%s): actual hung expected done", ctx);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule